// File: doc/BRIEF.md
# ECC Error Capture Log

This block keeps a record of a memory ECC error so that software can read it at its own pace. The ECC checker sends it a one-cycle strobe for each detected error, together with the error class (correctable single-bit or uncorrectable multi-bit), the 8-bit syndrome and the full 34-bit byte address of the failing access. The block holds a syndrome register and a 32-bit address pointer register. It also drives two sticky flags, one for each error class. Software reads the registers and flags through the outputs and acknowledges them with a one-cycle clear pulse.

Which error stays recorded follows an asymmetric lock rule. The first error after a clear fills both registers and locks them. A multi-bit error that arrives while only a single-bit error is recorded replaces that record. Every other error that arrives while the registers are locked still sets its class flag, but the registers keep their values. The address pointer keeps the 32-byte unit address: the byte offset below bit 5 is dropped, and the result is placed one bit up inside the register.

Top module: `ecc_err_log`

## Requirements
- R1: While reset is asserted, the syndrome register, the address pointer register and both flags are zero.
- R2: When the address pointer register is loaded, bits 29:1 take address bits 33:5, and bits 31:30 and bit 0 are zero. For example, address 3_FFFF_FFFFh gives 3FFF_FFFEh, and address 01Fh gives 0000_0000h.
- R3: When neither flag is set, an error strobe loads the syndrome and the address pointer one cycle later.
- R4: When the single-bit flag is set and the multi-bit flag is clear, a multi-bit error overwrites both registers. Afterwards both flags are set.
- R5: When the multi-bit flag is set, no error changes the registers. When only the single-bit flag is set, a single-bit error does not change them either.
- R6: Each error strobe sets the flag of its class (errMulti = 1 for multi-bit, 0 for single-bit), even when its data is not recorded. The flags stay set until a clear.
- R7: A clear pulse with no error present resets both flags on the next cycle and unlocks the registers, which keep their contents.
- R8: When a clear and an error strobe arrive in the same cycle, the clear takes effect first. The new error is recorded, and only its own class flag is set afterwards.
- R9: In a cycle with no error strobe, both registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| errValid | input | 1 | One-cycle strobe that marks an ECC error |
| errMulti | input | 1 | Error class: 1 for multi-bit, 0 for single-bit |
| errSyndrome | input | 8 | Syndrome of the error |
| errAddr | input | 34 | Byte address of the failing access |
| swClear | input | 1 | Software clear pulse for the flags and the lock |
| syndromeReg | output | 8 | Recorded syndrome |
| addrPtrReg | output | 32 | Recorded 32-byte unit address, stored in bits 29:1 |
| singleFlag | output | 1 | Sticky flag for single-bit errors |
| multiFlag | output | 1 | Sticky flag for multi-bit errors |

## Verification
The assertions assume that errMulti, errSyndrome and errAddr are valid whenever errValid is high, and that the register contents are only of interest after a strobe. No protocol limit is assumed on how often strobes or clears arrive, so back-to-back strobes and a strobe in the same cycle as a clear are legal. The random stimulus draws every data field freshly each cycle. It asserts a strobe or a clear independently, which often puts the block in the locked states and often produces the same-cycle clear-and-error case. Directed steps add the full-width and sub-32-byte address cases.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  // Load strobes passed from the lock control to the capture registers
  typedef struct packed {
    logic loadSyn;
    logic loadAddr;
  } logCtrl_t;
endpackage

// File: rtl/ecc_log_ctrl.sv
module ecc_log_ctrl
  import ecc_log_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     errValid,
  input  logic     errMulti,
  input  logic     swClear,
  output logCtrl_t ctrl,
  output logic     singleFlag,
  output logic     multiFlag
);
  logic sglQ, mbeQ;
  logic sglKeep, mbeKeep, takeErr;

  // The clear acts before the incoming error, so a same-cycle error sees an unlocked log
  always_comb begin
    sglKeep = sglQ & ~swClear;
    mbeKeep = mbeQ & ~swClear;
    takeErr = errValid & ((~sglKeep & ~mbeKeep) | (errMulti & ~mbeKeep));
    ctrl.loadSyn  = takeErr;
    ctrl.loadAddr = takeErr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sglQ <= 1'b0;
      mbeQ <= 1'b0;
    end else begin
      sglQ <= sglKeep | (errValid & ~errMulti);
      mbeQ <= mbeKeep | (errValid &  errMulti);
    end
  end

  assign singleFlag = sglQ;
  assign multiFlag  = mbeQ;
endmodule

// File: rtl/ecc_log_dp.sv
module ecc_log_dp
  import ecc_log_pkg::*;
#(
  parameter int SYN_W   = 8,
  parameter int ADDR_W  = 34,
  parameter int ALIGN   = 5,
  parameter int PTR_W   = 32,
  parameter int PTR_LSB = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logCtrl_t          ctrl,
  input  logic [SYN_W-1:0]  errSyndrome,
  input  logic [ADDR_W-1:0] errAddr,
  output logic [SYN_W-1:0]  syndromeReg,
  output logic [PTR_W-1:0]  addrPtrReg
);
  localparam int FIELD_W = ADDR_W - ALIGN;
  localparam int TOP_PAD = PTR_W - FIELD_W - PTR_LSB;

  logic [SYN_W-1:0]   synQ;
  logic [FIELD_W-1:0] unitQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) synQ <= '0;
    else if (ctrl.loadSyn) synQ <= errSyndrome;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) unitQ <= '0;
    else if (ctrl.loadAddr) unitQ <= errAddr[ADDR_W-1:ALIGN];
  end

  assign syndromeReg = synQ;

  generate
    if (PTR_LSB > 0) begin : g_lowPad
      assign addrPtrReg = {{TOP_PAD{1'b0}}, unitQ, {PTR_LSB{1'b0}}};
    end else begin : g_noLowPad
      assign addrPtrReg = {{TOP_PAD{1'b0}}, unitQ};
    end
  endgenerate
endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
  import ecc_log_pkg::*;
#(
  parameter int SYN_W   = 8,
  parameter int ADDR_W  = 34,
  parameter int ALIGN   = 5,
  parameter int PTR_W   = 32,
  parameter int PTR_LSB = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              errValid,
  input  logic              errMulti,
  input  logic [SYN_W-1:0]  errSyndrome,
  input  logic [ADDR_W-1:0] errAddr,
  input  logic              swClear,
  output logic [SYN_W-1:0]  syndromeReg,
  output logic [PTR_W-1:0]  addrPtrReg,
  output logic              singleFlag,
  output logic              multiFlag
);
  logCtrl_t ctrl;

  ecc_log_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .errValid   (errValid),
    .errMulti   (errMulti),
    .swClear    (swClear),
    .ctrl       (ctrl),
    .singleFlag (singleFlag),
    .multiFlag  (multiFlag)
  );

  ecc_log_dp #(
    .SYN_W   (SYN_W),
    .ADDR_W  (ADDR_W),
    .ALIGN   (ALIGN),
    .PTR_W   (PTR_W),
    .PTR_LSB (PTR_LSB)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .errSyndrome (errSyndrome),
    .errAddr     (errAddr),
    .syndromeReg (syndromeReg),
    .addrPtrReg  (addrPtrReg)
  );
endmodule

// File: rtl/ecc_err_log_chk.sv
module ecc_err_log_chk #(
  parameter int SYN_W   = 8,
  parameter int ADDR_W  = 34,
  parameter int ALIGN   = 5,
  parameter int PTR_W   = 32,
  parameter int PTR_LSB = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              errValid,
  input logic              errMulti,
  input logic [SYN_W-1:0]  errSyndrome,
  input logic [ADDR_W-1:0] errAddr,
  input logic              swClear,
  input logic [SYN_W-1:0]  syndromeReg,
  input logic [PTR_W-1:0]  addrPtrReg,
  input logic              singleFlag,
  input logic              multiFlag
);
  localparam int FIELD_W = ADDR_W - ALIGN;
  localparam int HI      = PTR_LSB + FIELD_W - 1;

  p_reset_r1: assert property (@(posedge clk)
    !rstN |=> (syndromeReg == '0 && addrPtrReg == '0 && !singleFlag && !multiFlag));

  p_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    (errValid && !singleFlag && !multiFlag) |=>
      (syndromeReg == $past(errSyndrome) && addrPtrReg[HI:PTR_LSB] == $past(errAddr[ADDR_W-1:ALIGN])));

  p_upgrade_r4: assert property (@(posedge clk) disable iff (!rstN)
    (errValid && errMulti && singleFlag && !multiFlag && !swClear) |=>
      (syndromeReg == $past(errSyndrome) && singleFlag && multiFlag));

  p_locked_r5: assert property (@(posedge clk) disable iff (!rstN)
    (errValid && !swClear && (multiFlag || (singleFlag && !errMulti))) |=>
      ($stable(syndromeReg) && $stable(addrPtrReg)));

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!swClear && (singleFlag || (errValid && !errMulti))) |=> singleFlag);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (swClear && !errValid) |=> (!singleFlag && !multiFlag && $stable(syndromeReg)));

  p_clr_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    (swClear && errValid) |=>
      (syndromeReg == $past(errSyndrome) && (multiFlag == $past(errMulti)) && (singleFlag != multiFlag)));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !errValid |=> ($stable(syndromeReg) && $stable(addrPtrReg)));
endmodule

bind ecc_err_log ecc_err_log_chk #(
  .SYN_W   (SYN_W),
  .ADDR_W  (ADDR_W),
  .ALIGN   (ALIGN),
  .PTR_W   (PTR_W),
  .PTR_LSB (PTR_LSB)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .errValid    (errValid),
  .errMulti    (errMulti),
  .errSyndrome (errSyndrome),
  .errAddr     (errAddr),
  .swClear     (swClear),
  .syndromeReg (syndromeReg),
  .addrPtrReg  (addrPtrReg),
  .singleFlag  (singleFlag),
  .multiFlag   (multiFlag)
);

// File: tb/ecc_err_log_tb.sv
`timescale 1ns/1ps
module ecc_err_log_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        errValid, errMulti, swClear;
  logic [7:0]  errSyndrome;
  logic [33:0] errAddr;
  logic [7:0]  syndromeReg;
  logic [31:0] addrPtrReg;
  logic        singleFlag, multiFlag;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Model state, kept from the requirements
  logic [7:0]  mSyn;
  logic [31:0] mPtr;
  logic        mS, mM;

  always #4 clk = ~clk;

  ecc_err_log u_dut (
    .clk(clk), .rstN(rstN), .errValid(errValid), .errMulti(errMulti),
    .errSyndrome(errSyndrome), .errAddr(errAddr), .swClear(swClear),
    .syndromeReg(syndromeReg), .addrPtrReg(addrPtrReg),
    .singleFlag(singleFlag), .multiFlag(multiFlag)
  );

  function automatic logic [31:0] ptrOf(input logic [33:0] a);
    return {2'b00, a[33:5], 1'b0};
  endfunction

  function automatic logic acceptErr(input logic v, input logic m, input logic s0, input logic m0);
    return v & ((~s0 & ~m0) | (m & ~m0));
  endfunction

  task automatic compareAll(input string tag);
    checks++;
    if (syndromeReg !== mSyn || addrPtrReg !== mPtr || singleFlag !== mS || multiFlag !== mM) begin
      errors++;
      $display("FAIL %s: got syn=%h ptr=%h s=%b m=%b, expected syn=%h ptr=%h s=%b m=%b",
               tag, syndromeReg, addrPtrReg, singleFlag, multiFlag, mSyn, mPtr, mS, mM);
    end
  endtask

  task automatic step(input logic v, input logic m, input logic [7:0] syn,
                      input logic [33:0] a, input logic clr, input string force_tag);
    logic  sK, mK, take;
    string tag;
    @(negedge clk);
    errValid = v; errMulti = m; errSyndrome = syn; errAddr = a; swClear = clr;
    sK   = mS & ~clr;
    mK   = mM & ~clr;
    take = acceptErr(v, m, sK, mK);
    if (clr && v)             tag = "R8";
    else if (take && (sK))    tag = "R4";
    else if (take)            tag = "R3";
    else if (v)               tag = "R5";
    else if (clr)             tag = "R7";
    else                      tag = "R9";
    if (force_tag != "") tag = force_tag;
    if (take) begin mSyn = syn; mPtr = ptrOf(a); end
    mS = sK | (v & ~m);
    mM = mK | (v & m);
    @(posedge clk);
    #1;
    errValid = 1'b0; swClear = 1'b0;
    compareAll(tag);
  endtask

  task automatic checkPtr(input logic [31:0] exp, input string tag);
    checks++;
    if (addrPtrReg !== exp) begin
      errors++;
      $display("FAIL %s: got ptr=%h, expected ptr=%h", tag, addrPtrReg, exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    rstN = 1'b0; errValid = 1'b0; errMulti = 1'b0; swClear = 1'b0;
    errSyndrome = '0; errAddr = '0;
    mSyn = '0; mPtr = '0; mS = 1'b0; mM = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compareAll("R1");
    rstN = 1'b1;

    // Directed corner cases
    step(1, 0, 8'h11, 34'h0_1234_5660, 0, "");    // R3 first single-bit error
    step(1, 0, 8'h22, 34'h0_0000_0040, 0, "");    // R5 second single-bit dropped
    step(1, 1, 8'h33, 34'h3_FFFF_FFFF, 0, "");    // R4 multi-bit overwrites single
    checkPtr(32'h3FFF_FFFE, "R2");                // full-width address
    step(1, 1, 8'h44, 34'h0_0000_0080, 0, "");    // R5 multi after multi dropped
    step(0, 0, 8'h00, 34'h0, 1, "");              // R7 clear keeps registers
    step(1, 1, 8'h55, 34'h1_0000_0020, 0, "");    // R3 first multi-bit error
    step(1, 0, 8'h66, 34'h2_0000_0000, 0, "R6");  // R6 single flag sets, data dropped
    step(1, 0, 8'h77, 34'h0_0000_001F, 1, "");    // R8 clear and error together
    checkPtr(32'h0000_0000, "R2");                // sub-32-byte bits dropped
    step(0, 1, 8'hEE, 34'h3_0000_0000, 0, "");    // R9 idle, no change
    step(1, 1, 8'h88, 34'h0_ABCD_EF00, 1, "");    // R8 multi with clear

    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] wide;
      wide = {$urandom, $urandom};
      step(($urandom % 10) < 3, $urandom % 2, 8'($urandom), wide[33:0],
           ($urandom % 10) == 0, "");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule